// File: doc/BRIEF.md
# Multi-Target Interrupt Router

The block collects 64 interrupt sources and routes them to four processors: three application cores and one I/O core. Each processor keeps its own sticky flags for every source and its own enable masks. A processor's interrupt line is high while any of its enabled flags is set. The I/O core has two lines, an IRQ line and a fast-interrupt (FIQ) line, and each line has its own enable masks.

The sources fall into two groups of 32. The lower group is `src_i[31:0]` and the upper group is `src_i[63:32]`. A rising edge on a source sets the matching flag in all four processors' status registers. Software clears a flag by writing 1 to its bit. All registers are reached over a plain 32-bit register bus.

A compatibility window at low addresses gives a second view of the lower group. This window covers only application core 0 and the I/O core, and it aliases their registers, so a write through one view is seen in the other.

Top module: `irq_router`

## Requirements
- R1: While reset is asserted and after it is released, every flag and every enable bit is 0. All interrupt lines are low and `rdata_o` is 0.
- R2: A 0-to-1 transition of `src_i[b]` sets flag `b mod 32` in the lower-group status of every processor (b < 32) or in the upper-group status (b ≥ 32), at the clock edge where the new level is first sampled. A source held high does not set the flag again once the flag has been cleared.
- R3: A bus write to a status register clears each flag whose write-data bit is 1 and leaves each flag whose write-data bit is 0 unchanged.
- R4: If a flag's source rises in the same cycle as a write that clears that flag, the flag stays at 1.
- R5: Enable registers are read/write and hold the last value written to them.
- R6: `app_irq_o[n]` is high exactly when some flag of core n is set in either group and its bit is also set in that core's enable register for the same group.
- R7: `io_irq_o` is the OR over both groups of the I/O core's flags ANDed with its IRQ enables. `io_fiq_o` is the same OR taken with its FIQ enables.
- R8: The main register map uses byte addresses.
  - Application core n has its base at 0x440+0x10·n, with lower status at +0, upper status at +4, lower enable at +8 and upper enable at +0xC.
  - The I/O core has lower status at 0x470, upper status at 0x474, IRQ enables at 0x478 (lower) and 0x47C (upper), and FIQ enables at 0x480 (lower) and 0x484 (upper).
- R9: The compatibility window covers only the lower group.
  - 0x30 is core 0's status and 0x34 is core 0's enable.
  - 0x38 is the I/O core's status, 0x3C its IRQ enable and 0x40 its FIQ enable.
  - These addresses alias the matching main-map registers, for reads and for writes.
- R10: A read of any address that is not mapped, including an address that is not a multiple of 4, returns 0. A write to such an address changes no register.
- R11: Read data appears on `rdata_o` one cycle after a read request (`req_i`=1, `we_i`=0). In every cycle without a read request, `rdata_o` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Interrupt sources; bits 31:0 are the lower group and bits 63:32 the upper group |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| app_irq_o | output | 3 | Interrupt line of each application core |
| io_irq_o | output | 1 | I/O core IRQ line |
| io_fiq_o | output | 1 | I/O core FIQ line |

## Verification
The bench raises each of the 64 sources in turn and reads all eight status registers after each one. This shows whether the group split and the bit position are correct, and whether every processor receives the flag. It then clears the flag one processor at a time, which separates per-processor clearing from a shared flag.

Each enable register is written with a unique pattern and then every register is read back. This shows up address aliasing and decode overlap, and the compatibility window is exercised both ways. Single-bit enable and flag combinations separate IRQ from FIQ and the lower group from the upper group.

Three further patterns cover the edge cases: a source held high across a clear, which shows edge detection as opposed to level capture; a clear that coincides with a rising edge; and accesses to unmapped or misaligned addresses.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned ADDR_W     = 12;
  localparam int unsigned DATA_W     = 32;
  localparam logic [ADDR_W-1:0] APP_BASE   = 12'h440;
  localparam logic [ADDR_W-1:0] APP_STRIDE = 12'h010;
  localparam logic [ADDR_W-1:0] IO_BASE    = 12'h470;
  localparam logic [ADDR_W-1:0] LEG_APP_ST = 12'h030;
  localparam logic [ADDR_W-1:0] LEG_APP_EN = 12'h034;
  localparam logic [ADDR_W-1:0] LEG_IO_ST  = 12'h038;
  localparam logic [ADDR_W-1:0] LEG_IO_IRQ = 12'h03c;
  localparam logic [ADDR_W-1:0] LEG_IO_FIQ = 12'h040;
endpackage

// File: rtl/irq_src_edge.sv
module irq_src_edge #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] src_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_i;
  end

  assign rise_o = src_i & ~src_q;
endmodule

// File: rtl/irq_core_bank.sv
module irq_core_bank #(
  parameter int unsigned GRP_W   = 32,
  parameter int unsigned NUM_SET = 1
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic [1:0][GRP_W-1:0]                   rise_i,
  input  logic [1:0]                              st_we_i,
  input  logic [NUM_SET-1:0][1:0]                 en_we_i,
  input  logic [GRP_W-1:0]                        wdata_i,
  output logic [1:0][GRP_W-1:0]                   st_o,
  output logic [NUM_SET-1:0][1:0][GRP_W-1:0]      en_o,
  output logic [NUM_SET-1:0]                      line_o
);
  logic [1:0][GRP_W-1:0]              st_q;
  logic [NUM_SET-1:0][1:0][GRP_W-1:0] en_q;

  for (genvar g = 0; g < 2; g++) begin : g_grp
    logic [GRP_W-1:0] clr;
    assign clr = st_we_i[g] ? wdata_i : '0;
    // set beats clear on the same bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= '0;
      else         st_q[g] <= (st_q[g] & ~clr) | rise_i[g];
    end

    for (genvar s = 0; s < NUM_SET; s++) begin : g_set
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           en_q[s][g] <= '0;
        else if (en_we_i[s][g]) en_q[s][g] <= wdata_i;
      end
    end
  end

  for (genvar s = 0; s < NUM_SET; s++) begin : g_line
    assign line_o[s] = |(st_q[0] & en_q[s][0]) | |(st_q[1] & en_q[s][1]);
  end

  assign st_o = st_q;
  assign en_o = en_q;
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_APP = 3,
  parameter int unsigned GRP_W   = 32,
  localparam int unsigned NUM_TGT = NUM_APP + 1,
  localparam int unsigned TGT_W   = $clog2(NUM_TGT)
) (
  input  logic                                   req_i,
  input  logic                                   we_i,
  input  logic [ADDR_W-1:0]                      addr_i,
  input  logic [NUM_TGT-1:0][1:0][GRP_W-1:0]     st_i,
  input  logic [NUM_TGT-1:0][1:0][1:0][GRP_W-1:0] en_i,
  output logic [NUM_TGT-1:0][1:0]                st_we_o,
  output logic [NUM_TGT-1:0][1:0][1:0]           en_we_o,
  output logic [GRP_W-1:0]                       rd_data_o
);
  typedef struct packed {
    logic             hit;
    logic             is_st;
    logic             set;
    logic             grp;
    logic [TGT_W-1:0] tgt;
  } sel_t;

  sel_t sel;

  always_comb begin
    logic [ADDR_W-1:0] base, off, span;
    sel = '0;
    for (int n = 0; n < NUM_TGT; n++) begin
      base = (n < NUM_APP) ? APP_BASE + ADDR_W'(n) * APP_STRIDE : IO_BASE;
      span = (n < NUM_APP) ? ADDR_W'(16) : ADDR_W'(24);
      off  = addr_i - base;
      if (addr_i >= base && off < span && off[1:0] == 2'b00) begin
        sel.hit   = 1'b1;
        sel.tgt   = TGT_W'(n);
        sel.is_st = (off[4:3] == 2'b00);
        sel.set   = off[4];
        sel.grp   = off[2];
      end
    end
    // compatibility window, lower group only
    unique case (addr_i)
      LEG_APP_ST: sel = '{hit: 1'b1, is_st: 1'b1, set: 1'b0, grp: 1'b0, tgt: '0};
      LEG_APP_EN: sel = '{hit: 1'b1, is_st: 1'b0, set: 1'b0, grp: 1'b0, tgt: '0};
      LEG_IO_ST:  sel = '{hit: 1'b1, is_st: 1'b1, set: 1'b0, grp: 1'b0, tgt: TGT_W'(NUM_APP)};
      LEG_IO_IRQ: sel = '{hit: 1'b1, is_st: 1'b0, set: 1'b0, grp: 1'b0, tgt: TGT_W'(NUM_APP)};
      LEG_IO_FIQ: sel = '{hit: 1'b1, is_st: 1'b0, set: 1'b1, grp: 1'b0, tgt: TGT_W'(NUM_APP)};
      default: ;
    endcase
  end

  always_comb begin
    st_we_o = '0;
    en_we_o = '0;
    if (req_i && we_i && sel.hit) begin
      if (sel.is_st) st_we_o[sel.tgt][sel.grp]          = 1'b1;
      else           en_we_o[sel.tgt][sel.set][sel.grp] = 1'b1;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (sel.hit) begin
      rd_data_o = sel.is_st ? st_i[sel.tgt][sel.grp] : en_i[sel.tgt][sel.set][sel.grp];
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_APP = 3,
  parameter int unsigned GRP_W   = 32,
  localparam int unsigned NUM_TGT = NUM_APP + 1,
  localparam int unsigned SRC_W   = 2 * GRP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SRC_W-1:0]   src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [GRP_W-1:0]   wdata_i,
  output logic [GRP_W-1:0]   rdata_o,
  output logic [NUM_APP-1:0] app_irq_o,
  output logic               io_irq_o,
  output logic               io_fiq_o
);
  logic [1:0][GRP_W-1:0]                    rise_w;
  logic [NUM_TGT-1:0][1:0][GRP_W-1:0]       st_all;
  logic [NUM_TGT-1:0][1:0][1:0][GRP_W-1:0]  en_all;
  logic [NUM_TGT-1:0][1:0]                  st_we_w;
  logic [NUM_TGT-1:0][1:0][1:0]             en_we_w;
  logic [GRP_W-1:0]                         rd_w;
  logic [GRP_W-1:0]                         rdata_q;

  irq_src_edge #(.WIDTH(SRC_W)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .rise_o (rise_w)
  );

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    localparam int unsigned NS = (t < NUM_APP) ? 1 : 2;
    logic [NS-1:0][1:0][GRP_W-1:0] en_w;
    logic [NS-1:0]                 line_w;

    irq_core_bank #(.GRP_W(GRP_W), .NUM_SET(NS)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rise_i  (rise_w),
      .st_we_i (st_we_w[t]),
      .en_we_i (en_we_w[t][NS-1:0]),
      .wdata_i (wdata_i),
      .st_o    (st_all[t]),
      .en_o    (en_w),
      .line_o  (line_w)
    );

    if (t < NUM_APP) begin : g_app
      assign en_all[t][0] = en_w[0];
      assign en_all[t][1] = '0;
      assign app_irq_o[t] = line_w[0];
    end else begin : g_io
      assign en_all[t] = en_w;
      assign io_irq_o  = line_w[0];
      assign io_fiq_o  = line_w[NS-1];
    end
  end

  irq_reg_decode #(.NUM_APP(NUM_APP), .GRP_W(GRP_W)) u_dec (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .st_i      (st_all),
    .en_i      (en_all),
    .st_we_o   (st_we_w),
    .en_we_o   (en_we_w),
    .rd_data_o (rd_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_w;
    else                     rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int unsigned NUM_APP = 3,
  parameter int unsigned GRP_W   = 32,
  localparam int unsigned NUM_TGT = NUM_APP + 1
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               req_i,
  input logic                               we_i,
  input logic [GRP_W-1:0]                   wdata_i,
  input logic [GRP_W-1:0]                   rdata_o,
  input logic [NUM_APP-1:0]                 app_irq_o,
  input logic                               io_irq_o,
  input logic                               io_fiq_o,
  input logic [1:0][GRP_W-1:0]              rise_w,
  input logic [NUM_TGT-1:0][1:0][GRP_W-1:0] st_all,
  input logic [NUM_TGT-1:0][1:0]            st_we_w
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (app_irq_o == '0 && !io_irq_o && !io_fiq_o && rdata_o == '0);
    end
  end

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_t
    for (genvar g = 0; g < 2; g++) begin : g_g
      // R2 and R4: every rising source is captured even under a clear
      assert_rise_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((st_all[t][g] & $past(rise_w[g])) == $past(rise_w[g])));
      assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((st_all[t][g] & ~$past(st_all[t][g]) & ~$past(rise_w[g])) == '0));
      assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(st_all[t][g]) & ~($past(st_we_w[t][g]) ? $past(wdata_i) : '0)
                   & ~st_all[t][g]) == '0));
    end
  end

  assert_app_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|app_irq_o) |-> $past(req_i && we_i));
  assert_io_irq_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(io_irq_o) |-> $past(req_i && we_i));
  assert_io_fiq_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(io_fiq_o) |-> $past(req_i && we_i));
  assert_idle_rdata_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> (rdata_o == '0));
endmodule

bind irq_router irq_router_chk #(.NUM_APP(NUM_APP), .GRP_W(GRP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .app_irq_o (app_irq_o),
  .io_irq_o  (io_irq_o),
  .io_fiq_o  (io_fiq_o),
  .rise_w    (rise_w),
  .st_all    (st_all),
  .st_we_w   (st_we_w)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [2:0]  app_irq_o;
  logic        io_irq_o, io_fiq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model: status [tgt][grp], enable [tgt][set][grp]
  logic [31:0] m_st [4][2];
  logic [31:0] m_en [4][2][2];

  always #10ns clk_i = ~clk_i;

  irq_router dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .app_irq_o(app_irq_o),
    .io_irq_o(io_irq_o), .io_fiq_o(io_fiq_o)
  );

  function automatic logic [11:0] st_addr(int t, int g);
    return (t < 3) ? 12'(12'h440 + 16 * t + 4 * g) : 12'(12'h470 + 4 * g);
  endfunction

  function automatic logic [11:0] en_addr(int t, int s, int g);
    return (t < 3) ? 12'(12'h448 + 16 * t + 4 * g) : 12'(12'h478 + 8 * s + 4 * g);
  endfunction

  task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic rd_chk(string rq, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    check(rq, $sformatf("read %h", a), d, exp);
  endtask

  task automatic chk_status(string rq);
    for (int t = 0; t < 4; t++)
      for (int g = 0; g < 2; g++) rd_chk(rq, st_addr(t, g), m_st[t][g]);
  endtask

  task automatic chk_enables(string rq);
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < ((t < 3) ? 1 : 2); s++)
        for (int g = 0; g < 2; g++) rd_chk(rq, en_addr(t, s, g), m_en[t][s][g]);
  endtask

  task automatic chk_lines(string rq);
    logic [2:0] ea;
    for (int t = 0; t < 3; t++)
      ea[t] = |(m_st[t][0] & m_en[t][0][0]) | |(m_st[t][1] & m_en[t][0][1]);
    check(rq, "app lines", {29'd0, app_irq_o}, {29'd0, ea});
    check(rq, "io irq", {31'd0, io_irq_o},
          {31'd0, |(m_st[3][0] & m_en[3][0][0]) | |(m_st[3][1] & m_en[3][0][1])});
    check(rq, "io fiq", {31'd0, io_fiq_o},
          {31'd0, |(m_st[3][0] & m_en[3][1][0]) | |(m_st[3][1] & m_en[3][1][1])});
  endtask

  task automatic set_model(int b);
    for (int t = 0; t < 4; t++) m_st[t][b / 32][b % 32] = 1'b1;
  endtask

  task automatic pulse(int b);
    @(negedge clk_i); src_i[b] = 1'b1;
    @(negedge clk_i); src_i[b] = 1'b0;
    set_model(b);
  endtask

  task automatic en_wr(int t, int s, int g, logic [31:0] d);
    bus_wr(en_addr(t, s, g), d);
    m_en[t][s][g] = d;
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int t = 0; t < 4; t++)
      for (int g = 0; g < 2; g++) begin
        m_st[t][g] = '0;
        m_en[t][0][g] = '0;
        m_en[t][1][g] = '0;
      end
    repeat (3) @(negedge clk_i);
    check("R1", "rdata in reset", rdata_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_lines("R1");
    chk_status("R1");
    chk_enables("R1");

    // R5 R8: unique pattern into every enable register, then read all back
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < ((t < 3) ? 1 : 2); s++)
        for (int g = 0; g < 2; g++)
          en_wr(t, s, g, 32'h9e37_79b9 * (t * 4 + s * 2 + g + 1));
    chk_enables("R5");
    chk_status("R8");

    // R9: the compatibility window aliases the lower-group registers
    rd_chk("R9", 12'h034, m_en[0][0][0]);
    rd_chk("R9", 12'h03c, m_en[3][0][0]);
    rd_chk("R9", 12'h040, m_en[3][1][0]);
    bus_wr(12'h034, 32'h0000_f00d); m_en[0][0][0] = 32'h0000_f00d;
    bus_wr(12'h03c, 32'h1234_0000); m_en[3][0][0] = 32'h1234_0000;
    bus_wr(12'h040, 32'h00c0_ffee); m_en[3][1][0] = 32'h00c0_ffee;
    chk_enables("R9");

    // R10: unmapped and misaligned accesses
    rd_chk("R10", 12'h000, '0);
    rd_chk("R10", 12'h43c, '0);
    rd_chk("R10", 12'h488, '0);
    rd_chk("R10", 12'h442, '0);
    rd_chk("R10", 12'h044, '0);
    rd_chk("R10", 12'h7fc, '0);
    bus_wr(12'h488, 32'hffff_ffff);
    bus_wr(12'h44a, 32'hffff_ffff);
    bus_wr(12'h02c, 32'hffff_ffff);
    chk_enables("R10");

    // R11: data one cycle after the request, zero when idle
    bus_rd(12'h448, d);
    check("R11", "read latency", d, m_en[0][0][0]);
    @(negedge clk_i);
    check("R11", "idle rdata", rdata_o, '0);

    // clear enables for flag sweeps
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < ((t < 3) ? 1 : 2); s++)
        for (int g = 0; g < 2; g++) en_wr(t, s, g, '0);

    // R2 R3: each source in turn, then a per-target clear
    for (int b = 0; b < 64; b++) begin
      pulse(b);
      chk_status("R2");
      for (int t = 0; t < 4; t++) begin
        bus_wr(st_addr(t, b / 32), 32'h1 << (b % 32));
        m_st[t][b / 32][b % 32] = 1'b0;
        rd_chk("R3", st_addr(t, b / 32), m_st[t][b / 32]);
      end
    end

    // R3: writing zeros keeps flags, partial clear keeps the rest
    pulse(4); pulse(9); pulse(33);
    bus_wr(st_addr(1, 0), 32'h0);
    chk_status("R3");
    bus_wr(st_addr(1, 0), 32'h0000_0010); m_st[1][0][4] = 1'b0;
    chk_status("R3");

    // R2: level held high is not recaptured after a clear
    @(negedge clk_i); src_i[20] = 1'b1; set_model(20);
    bus_wr(st_addr(2, 0), 32'h0010_0000); m_st[2][0][20] = 1'b0;
    repeat (3) @(negedge clk_i);
    rd_chk("R2", st_addr(2, 0), m_st[2][0]);
    src_i[20] = 1'b0;

    // R4: rising edge coincides with a clear of the same bit
    @(negedge clk_i);
    src_i[40] = 1'b1;
    req_i = 1'b1; we_i = 1'b1; addr_i = st_addr(0, 1); wdata_i = 32'h0000_0100;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; src_i[40] = 1'b0;
    set_model(40);
    rd_chk("R4", st_addr(0, 1), m_st[0][1]);

    // clear all flags through every target
    for (int t = 0; t < 4; t++)
      for (int g = 0; g < 2; g++) begin
        bus_wr(st_addr(t, g), 32'hffff_ffff);
        m_st[t][g] = '0;
      end
    chk_status("R3");

    // R6 R7: masked flags, then each enable in turn
    pulse(5); pulse(40);
    chk_lines("R6");
    en_wr(1, 0, 1, 32'h0000_0100);
    chk_lines("R6");
    check("R6", "app1 only", {29'd0, app_irq_o}, 32'd2);
    en_wr(0, 0, 0, 32'h0000_0020);
    chk_lines("R6");
    en_wr(3, 1, 0, 32'h0000_0020);
    chk_lines("R7");
    check("R7", "fiq without irq", {30'd0, io_irq_o, io_fiq_o}, 32'd1);
    en_wr(3, 0, 1, 32'h0000_0100);
    chk_lines("R7");
    bus_wr(12'h038, 32'h0000_0020); m_st[3][0][5] = 1'b0;
    chk_lines("R9");
    rd_chk("R9", 12'h470, m_st[3][0]);
    bus_wr(12'h030, 32'h0000_0020); m_st[0][0][5] = 1'b0;
    chk_lines("R9");
    bus_wr(st_addr(3, 1), 32'h0000_0100); m_st[3][1][8] = 1'b0;
    chk_lines("R7");
    bus_wr(st_addr(1, 1), 32'h0000_0100); m_st[1][1][8] = 1'b0;
    chk_lines("R6");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule